// File: doc/BRIEF.md
# Packed 52-bit Multiply-Add-High Unit

This block is a pipelined vector integer datapath working on a 512-bit operand bus split into 64-bit lanes. In each lane it takes the low 52 bits of two source elements, forms their 104-bit unsigned product and adds the upper 52 bits of that product to a 64-bit accumulator element. It is used to build wide modular arithmetic out of 52-bit limbs, where the high half of each limb product has to be folded into a running sum.

The accumulator comes in on its own bus and the new value leaves on the result bus. Lane writes are controlled by a per-lane mask. The mask can be switched off, and lanes with a clear mask bit are either zeroed or keep their accumulator value. The second source can be replaced by a broadcast of its lowest element. A vector-length select picks 2, 4 or 8 active lanes, and every bit above the active length is forced to zero. Three register stages sit between the input strobe and the result, and a new operation can be accepted on every clock.

Top module: `pmah_unit`

## Requirements
- R1: Bits 63:52 of every source element are ignored. Only bits 51:0 of each source element, zero-extended, enter the multiplier.
- R2: A written lane holds its accumulator element plus bits 103:52 of the 104-bit product of the two 52-bit source values, zero-extended to 64 bits.
- R3: The lane sum is taken modulo 2^64, so a carry out of bit 63 is lost.
- R4: `vl_sel` selects the number of active lanes: 0 gives 2 lanes (bits 127:0), 1 gives 4 lanes (bits 255:0), and 2 or 3 give 8 lanes. Every result bit at or above the active length is zero.
- R5: Lane j (bits 64j+63:64j) is written when `mask_en` is 0 or when `lane_mask[j]` is 1. Mask bits of inactive lanes have no effect on the result.
- R6: An active lane that is not written is zero when `zero_mode` is 1 and equals its accumulator element when `zero_mode` is 0.
- R7: When `bcast` is 1, every lane uses bits 51:0 of element 0 of `src_b` in place of its own `src_b` element.
- R8: `out_valid` rises exactly three clocks after an accepted `in_valid` and carries that operation's result. One operation is accepted per clock. A synchronous reset clears all in-flight valid bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| src_a | input | 512 | First multiplicand vector |
| src_b | input | 512 | Second multiplicand vector |
| acc_in | input | 512 | Accumulator vector (current destination) |
| lane_mask | input | 8 | Per-lane write mask, bit j for lane j |
| mask_en | input | 1 | 1: apply lane_mask; 0: write all active lanes |
| zero_mode | input | 1 | 1: zero unwritten lanes; 0: keep accumulator |
| bcast | input | 1 | 1: broadcast element 0 of src_b to every lane |
| vl_sel | input | 2 | Vector length select (see R4) |
| out_valid | output | 1 | Result valid |
| result | output | 512 | New destination vector |

## Verification
The hardest states to reach are the interactions between masking, vector length and a stream of operations in flight: a mask bit set on an inactive lane, a merged lane next to a zeroed one, and a carry out of bit 63. Random data alone hits these rarely. The stimulus therefore sweeps every mask value for each lane count in both masking modes, issues the operations back to back so that all three stages hold different work, and adds directed vectors with all-ones operands, set upper bits and a near-full accumulator. A reset is asserted while operations are in flight, to show that they are discarded.

// File: rtl/pmah_pkg.sv
package pmah_pkg;

    localparam int NUM_LANES = 8;
    localparam int ELEM_W    = 64;
    localparam int LIMB_W    = 52;
    localparam int VEC_W     = NUM_LANES * ELEM_W;
    localparam int PROD_W    = 2 * LIMB_W;

    typedef enum logic [1:0] {
        VL_X2   = 2'd0,
        VL_X4   = 2'd1,
        VL_X8   = 2'd2,
        VL_RSVD = 2'd3
    } vlen_e;

    typedef struct packed {
        logic                 mask_en;
        logic                 zero_mode;
        logic [NUM_LANES-1:0] mask;
        vlen_e                vl;
    } ctrl_t;

    // Number of live lanes for a length code, capped at the lane count.
    function automatic int lanes_for(vlen_e vl);
        int n;
        case (vl)
            VL_X2:   n = 2;
            VL_X4:   n = 4;
            default: n = NUM_LANES;
        endcase
        if (n > NUM_LANES) n = NUM_LANES;
        return n;
    endfunction

    function automatic logic [NUM_LANES-1:0] live_vector(vlen_e vl);
        logic [NUM_LANES-1:0] r;
        int n;
        n = lanes_for(vl);
        for (int j = 0; j < NUM_LANES; j++) r[j] = (j < n);
        return r;
    endfunction

endpackage

// File: rtl/pmah_issue_stage.sv
module pmah_issue_stage
    import pmah_pkg::*;
#(
    parameter int LANES  = NUM_LANES,
    parameter int LANE_W = ELEM_W,
    parameter int MUL_W  = LIMB_W
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         in_valid,
    input  logic [LANES*LANE_W-1:0]      src_a,
    input  logic [LANES*LANE_W-1:0]      src_b,
    input  logic [LANES*LANE_W-1:0]      acc_in,
    input  ctrl_t                        ctrl_in,
    input  logic                         bcast,
    output logic                         v_q,
    output logic [LANES-1:0][MUL_W-1:0]  a_q,
    output logic [LANES-1:0][MUL_W-1:0]  b_q,
    output logic [LANES-1:0][LANE_W-1:0] acc_q,
    output ctrl_t                        ctrl_q
);

    logic [LANES-1:0][MUL_W-1:0]  a_sel;
    logic [LANES-1:0][MUL_W-1:0]  b_sel;
    logic [LANES-1:0][LANE_W-1:0] acc_sel;
    logic [MUL_W-1:0]             b_bcast;

    // Operand narrowing: the cast keeps only the limb bits of each element.
    assign b_bcast = MUL_W'(src_b[LANE_W-1:0]);

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        assign a_sel[j]   = MUL_W'(src_a[j*LANE_W +: LANE_W]);
        assign b_sel[j]   = bcast ? b_bcast : MUL_W'(src_b[j*LANE_W +: LANE_W]);
        assign acc_sel[j] = acc_in[j*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk) begin
        if (rst) v_q <= 1'b0;
        else     v_q <= in_valid;
    end

    always_ff @(posedge clk) begin
        if (in_valid) begin
            a_q    <= a_sel;
            b_q    <= b_sel;
            acc_q  <= acc_sel;
            ctrl_q <= ctrl_in;
        end
    end

endmodule

// File: rtl/pmah_lane_mul.sv
module pmah_lane_mul #(
    parameter int MUL_W = 52
) (
    input  logic [MUL_W-1:0] op_a,
    input  logic [MUL_W-1:0] op_b,
    output logic [MUL_W-1:0] prod_hi
);

    localparam int FULL_W = 2 * MUL_W;

    logic [FULL_W-1:0] full;

    assign full    = {{MUL_W{1'b0}}, op_a} * {{MUL_W{1'b0}}, op_b};
    assign prod_hi = MUL_W'(full >> MUL_W);

endmodule

// File: rtl/pmah_product_stage.sv
module pmah_product_stage
    import pmah_pkg::*;
#(
    parameter int LANES  = NUM_LANES,
    parameter int LANE_W = ELEM_W,
    parameter int MUL_W  = LIMB_W
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         v_d,
    input  logic [LANES-1:0][MUL_W-1:0]  a_d,
    input  logic [LANES-1:0][MUL_W-1:0]  b_d,
    input  logic [LANES-1:0][LANE_W-1:0] acc_d,
    input  ctrl_t                        ctrl_d,
    output logic                         v_q,
    output logic [LANES-1:0][MUL_W-1:0]  hi_q,
    output logic [LANES-1:0][LANE_W-1:0] acc_q,
    output ctrl_t                        ctrl_q
);

    logic [LANES-1:0][MUL_W-1:0] hi_c;

    for (genvar j = 0; j < LANES; j++) begin : g_mul
        pmah_lane_mul #(.MUL_W(MUL_W)) u_mul (
            .op_a    (a_d[j]),
            .op_b    (b_d[j]),
            .prod_hi (hi_c[j])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) v_q <= 1'b0;
        else     v_q <= v_d;
    end

    always_ff @(posedge clk) begin
        if (v_d) begin
            hi_q   <= hi_c;
            acc_q  <= acc_d;
            ctrl_q <= ctrl_d;
        end
    end

endmodule

// File: rtl/pmah_merge_stage.sv
module pmah_merge_stage
    import pmah_pkg::*;
#(
    parameter int LANES  = NUM_LANES,
    parameter int LANE_W = ELEM_W,
    parameter int MUL_W  = LIMB_W
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         v_d,
    input  logic [LANES-1:0][MUL_W-1:0]  hi_d,
    input  logic [LANES-1:0][LANE_W-1:0] acc_d,
    input  ctrl_t                        ctrl_d,
    output logic                         v_q,
    output logic [LANES*LANE_W-1:0]      res_q
);

    logic [LANES-1:0]             live;
    logic [LANES-1:0]             wr;
    logic [LANES-1:0][LANE_W-1:0] lane_c;

    assign live = LANES'(live_vector(ctrl_d.vl));
    assign wr   = live & (ctrl_d.mask_en ? LANES'(ctrl_d.mask) : {LANES{1'b1}});

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        logic [LANE_W-1:0] sum;
        // Modulo 2^LANE_W: the carry out of the top bit is not kept.
        assign sum = acc_d[j] + LANE_W'(hi_d[j]);
        always_comb begin
            if (!live[j])          lane_c[j] = '0;
            else if (wr[j])        lane_c[j] = sum;
            else if (ctrl_d.zero_mode) lane_c[j] = '0;
            else                   lane_c[j] = acc_d[j];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) v_q <= 1'b0;
        else     v_q <= v_d;
    end

    always_ff @(posedge clk) begin
        if (v_d) res_q <= lane_c;
    end

endmodule

// File: rtl/pmah_unit.sv
module pmah_unit
    import pmah_pkg::*;
#(
    parameter int LANES  = NUM_LANES,
    parameter int LANE_W = ELEM_W,
    parameter int MUL_W  = LIMB_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic [LANES*LANE_W-1:0] src_a,
    input  logic [LANES*LANE_W-1:0] src_b,
    input  logic [LANES*LANE_W-1:0] acc_in,
    input  logic [LANES-1:0]        lane_mask,
    input  logic                    mask_en,
    input  logic                    zero_mode,
    input  logic                    bcast,
    input  logic [1:0]              vl_sel,
    output logic                    out_valid,
    output logic [LANES*LANE_W-1:0] result
);

    ctrl_t ctrl_in;
    always_comb begin
        ctrl_in           = '0;
        ctrl_in.mask_en   = mask_en;
        ctrl_in.zero_mode = zero_mode;
        ctrl_in.mask      = NUM_LANES'(lane_mask);
        ctrl_in.vl        = vlen_e'(vl_sel);
    end

    logic                         s1_v;
    logic [LANES-1:0][MUL_W-1:0]  s1_a;
    logic [LANES-1:0][MUL_W-1:0]  s1_b;
    logic [LANES-1:0][LANE_W-1:0] s1_acc;
    ctrl_t                        s1_ctrl;

    logic                         s2_v;
    logic [LANES-1:0][MUL_W-1:0]  s2_hi;
    logic [LANES-1:0][LANE_W-1:0] s2_acc;
    ctrl_t                        s2_ctrl;

    pmah_issue_stage #(.LANES(LANES), .LANE_W(LANE_W), .MUL_W(MUL_W)) u_issue (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .src_a    (src_a),
        .src_b    (src_b),
        .acc_in   (acc_in),
        .ctrl_in  (ctrl_in),
        .bcast    (bcast),
        .v_q      (s1_v),
        .a_q      (s1_a),
        .b_q      (s1_b),
        .acc_q    (s1_acc),
        .ctrl_q   (s1_ctrl)
    );

    pmah_product_stage #(.LANES(LANES), .LANE_W(LANE_W), .MUL_W(MUL_W)) u_prod (
        .clk    (clk),
        .rst    (rst),
        .v_d    (s1_v),
        .a_d    (s1_a),
        .b_d    (s1_b),
        .acc_d  (s1_acc),
        .ctrl_d (s1_ctrl),
        .v_q    (s2_v),
        .hi_q   (s2_hi),
        .acc_q  (s2_acc),
        .ctrl_q (s2_ctrl)
    );

    pmah_merge_stage #(.LANES(LANES), .LANE_W(LANE_W), .MUL_W(MUL_W)) u_merge (
        .clk    (clk),
        .rst    (rst),
        .v_d    (s2_v),
        .hi_d   (s2_hi),
        .acc_d  (s2_acc),
        .ctrl_d (s2_ctrl),
        .v_q    (out_valid),
        .res_q  (result)
    );

endmodule

// File: rtl/pmah_unit_chk.sv
module pmah_unit_chk
    import pmah_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [VEC_W-1:0] acc_in,
    input logic [NUM_LANES-1:0] lane_mask,
    input logic             mask_en,
    input logic             zero_mode,
    input logic [1:0]       vl_sel,
    input logic             out_valid,
    input logic [VEC_W-1:0] result
);

    logic [2:0]             v_sh;
    logic [2:0][VEC_W-1:0]  acc_sh;
    logic [2:0][NUM_LANES-1:0] mask_sh;
    logic [2:0]             men_sh;
    logic [2:0]             zm_sh;
    logic [2:0][1:0]        vl_sh;
    logic [NUM_LANES-1:0]   live_d;

    always_ff @(posedge clk) begin
        if (rst) v_sh <= '0;
        else     v_sh <= {v_sh[1:0], in_valid};
    end

    always_ff @(posedge clk) begin
        acc_sh  <= {acc_sh[1:0],  acc_in};
        mask_sh <= {mask_sh[1:0], lane_mask};
        men_sh  <= {men_sh[1:0],  mask_en};
        zm_sh   <= {zm_sh[1:0],   zero_mode};
        vl_sh   <= {vl_sh[1:0],   vl_sel};
    end

    assign live_d = live_vector(vlen_e'(vl_sh[2]));

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
        out_valid == v_sh[2]); // R8

    AST_UPPER_ZERO_X2: assert property (@(posedge clk) disable iff (rst)
        (out_valid && vl_sh[2] == 2'd0) |-> result[VEC_W-1:2*ELEM_W] == '0); // R4

    AST_UPPER_ZERO_X4: assert property (@(posedge clk) disable iff (rst)
        (out_valid && vl_sh[2] == 2'd1) |-> result[VEC_W-1:4*ELEM_W] == '0); // R4

    for (genvar j = 0; j < NUM_LANES; j++) begin : g_lane
        AST_ZERO_FILL: assert property (@(posedge clk) disable iff (rst)
            (out_valid && live_d[j] && men_sh[2] && zm_sh[2] && !mask_sh[2][j])
            |-> result[j*ELEM_W +: ELEM_W] == '0); // R6

        AST_MERGE_HOLD: assert property (@(posedge clk) disable iff (rst)
            (out_valid && live_d[j] && men_sh[2] && !zm_sh[2] && !mask_sh[2][j])
            |-> result[j*ELEM_W +: ELEM_W] == acc_sh[2][j*ELEM_W +: ELEM_W]); // R6
    end

endmodule

bind pmah_unit pmah_unit_chk u_chk (.*);

// File: tb/pmah_unit_test.sv
`timescale 1ns/1ps
module pmah_unit_test;

    localparam int W   = 512;
    localparam int NL  = 8;
    localparam int QD  = 1024;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic [W-1:0] src_a = '0, src_b = '0, acc_in = '0;
    logic [NL-1:0] lane_mask = '0;
    logic mask_en = 1'b0, zero_mode = 1'b0, bcast = 1'b0;
    logic [1:0] vl_sel = 2'd2;
    logic out_valid;
    logic [W-1:0] result;

    always #2.5 clk = ~clk;

    pmah_unit uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .src_a(src_a), .src_b(src_b),
        .acc_in(acc_in), .lane_mask(lane_mask), .mask_en(mask_en),
        .zero_mode(zero_mode), .bcast(bcast), .vl_sel(vl_sel),
        .out_valid(out_valid), .result(result)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int wr_ptr = 0;
    int rd_ptr = 0;
    logic [W-1:0] exp_q [QD];
    int           exp_cyc [QD];
    string        exp_tag [QD];
    logic [63:0]  seed = 64'h9E37_79B9_7F4A_7C15;

    always @(posedge clk) cyc <= cyc + 1;

    // Directed table: base values, lane spreading, controls and requirement tag.
    localparam int NT = 10;
    localparam logic [63:0] T_A [NT] = '{
        64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0123_4567_89AB_CDEF,
        64'h0FED_CBA9_8765_4321, 64'h000F_FFFF_FFFF_FFFF, 64'h5555_AAAA_5555_AAAA,
        64'h1357_9BDF_0246_8ACE, 64'hFFFF_0000_FFFF_0000, 64'hFFFF_FFFF_FFFF_FFFF,
        64'hFFFF_FFFF_FFFF_FFFF};
    localparam logic [63:0] T_B [NT] = '{
        64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'hDEAD_BEEF_CAFE_F00D,
        64'h1111_2222_3333_4444, 64'hFFF8_0000_1234_5678, 64'h3333_CCCC_3333_CCCC,
        64'h8642_0ECA_9753_1FDB, 64'h0F0F_F0F0_0F0F_F0F0, 64'hFFF0_0000_0000_0000,
        64'h8000_0000_0010_0000};
    localparam logic [63:0] T_C [NT] = '{
        64'h0000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 64'h7777_8888_9999_AAAA,
        64'h1234_1234_1234_1234, 64'h0BAD_F00D_0BAD_F00D, 64'hC0DE_C0DE_C0DE_C0DE,
        64'h0000_FFFF_0000_FFFF, 64'hFFFF_FFFF_FFF0_0000, 64'h2468_ACE0_1357_9BDF,
        64'hFFFF_FFFF_FFFF_FF00};
    localparam bit          T_SPREAD [NT] = '{1, 0, 1, 1, 1, 1, 1, 1, 0, 0};
    localparam logic [7:0]  T_MASK [NT]   = '{8'h00, 8'h00, 8'hA5, 8'h5A, 8'h0F, 8'hFF, 8'hF5, 8'h81, 8'h00, 8'h00};
    localparam logic [2:0]  T_FLAGS [NT]  = '{3'b000, 3'b000, 3'b100, 3'b110, 3'b001, 3'b000, 3'b100, 3'b110, 3'b000, 3'b001};
    localparam logic [1:0]  T_VL [NT]     = '{2'd2, 2'd2, 2'd2, 2'd2, 2'd2, 2'd0, 2'd1, 2'd3, 2'd2, 2'd2};
    localparam string       T_TAG [NT]    = '{"R1", "R3", "R6", "R6", "R7", "R4", "R5", "R4", "R1", "R2"};

    function automatic logic [W-1:0] expand(input logic [63:0] base, input bit spread);
        logic [W-1:0] v;
        for (int j = 0; j < NL; j++)
            v[j*64 +: 64] = spread ? (base ^ (64'(j) * 64'h0000_0F1E_2D3C_4B5A)) : base;
        return v;
    endfunction

    function automatic logic [W-1:0] ref_calc(input logic [W-1:0] a, b, c, input logic [7:0] m,
                                              input logic men, zm, bc, input logic [1:0] vl);
        logic [W-1:0] r;
        logic [127:0] ea, eb, p, s;
        int n;
        n = (vl == 2'd0) ? 2 : (vl == 2'd1) ? 4 : 8;
        for (int j = 0; j < NL; j++) begin
            if (j >= n) r[j*64 +: 64] = '0;
            else if (!men || m[j]) begin
                ea = {76'b0, a[j*64 +: 52]};
                eb = bc ? {76'b0, b[51:0]} : {76'b0, b[j*64 +: 52]};
                p  = ea * eb;
                s  = {64'b0, c[j*64 +: 64]} + (p >> 52);
                r[j*64 +: 64] = s[63:0];
            end else
                r[j*64 +: 64] = zm ? 64'b0 : c[j*64 +: 64];
        end
        return r;
    endfunction

    function automatic logic [63:0] rnd64();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 7);
        seed = seed ^ (seed << 17);
        return seed;
    endfunction

    task automatic issue(input logic [W-1:0] a, b, c, input logic [7:0] m,
                         input logic men, zm, bc, input logic [1:0] vl, input string tag);
        @(negedge clk);
        src_a = a; src_b = b; acc_in = c; lane_mask = m;
        mask_en = men; zero_mode = zm; bcast = bc; vl_sel = vl; in_valid = 1'b1;
        exp_q[wr_ptr]   = ref_calc(a, b, c, m, men, zm, bc, vl);
        exp_cyc[wr_ptr] = cyc;
        exp_tag[wr_ptr] = tag;
        wr_ptr++;
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // Monitor: results in issue order, three clocks after issue (R8).
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            checks++;
            if (rd_ptr >= wr_ptr) begin
                fails++;
                $display("FAIL R8: out_valid with no operation pending (actual 1, expected 0)");
            end else begin
                if (result !== exp_q[rd_ptr]) begin
                    fails++;
                    $display("FAIL %s: op %0d result actual %h expected %h",
                             exp_tag[rd_ptr], rd_ptr, result, exp_q[rd_ptr]);
                end
                checks++;
                if (cyc - exp_cyc[rd_ptr] != 3) begin
                    fails++;
                    $display("FAIL R8: op %0d latency actual %0d expected 3",
                             rd_ptr, cyc - exp_cyc[rd_ptr]);
                end
                rd_ptr++;
            end
        end
    end

    task automatic check_quiet(input string tag);
        checks++;
        if (out_valid !== 1'b0) begin
            fails++;
            $display("FAIL %s: out_valid actual %b expected 0", tag, out_valid);
        end
    endtask

    initial begin
        #500000;
        fails++;
        $display("FAIL watchdog: run did not finish (actual hung, expected done)");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [W-1:0] ra, rb, rc;
        repeat (3) @(negedge clk);
        check_quiet("R8");                  // R8 reset state
        rst = 1'b0;
        @(negedge clk);
        check_quiet("R8");

        // Table walk (R1..R7), issued back to back.
        for (int i = 0; i < NT; i++)
            issue(expand(T_A[i], T_SPREAD[i]), expand(T_B[i], T_SPREAD[i]),
                  expand(T_C[i], T_SPREAD[i]), T_MASK[i],
                  T_FLAGS[i][2], T_FLAGS[i][1], T_FLAGS[i][0], T_VL[i], T_TAG[i]);
        idle(4);

        // Every mask for 2, 4 and 8 lanes in both modes (R5, R6); mask bits
        // above the active count are randomised and must have no effect (R5).
        for (int v = 0; v < 3; v++) begin
            for (int zm = 0; zm < 2; zm++) begin
                for (int m = 0; m < (1 << (2 << v)); m++) begin
                    logic [7:0] mm;
                    for (int k = 0; k < NL; k++) begin
                        ra[k*64 +: 64] = rnd64();
                        rb[k*64 +: 64] = rnd64();
                        rc[k*64 +: 64] = rnd64();
                    end
                    mm = 8'(m) | (v == 2 ? 8'h00 : (8'(rnd64()) & ~8'((1 << (2 << v)) - 1)));
                    issue(ra, rb, rc, mm, 1'b1, 1'(zm), 1'(m % 3 == 0), 2'(v), "R5");
                end
            end
        end
        idle(4);

        // Carry out of bit 63 on every lane (R3) and broadcast with unmasked lanes (R7).
        issue({NL{64'h000F_FFFF_FFFF_FFFF}}, {NL{64'h000F_FFFF_FFFF_FFFF}},
              {NL{64'hFFFF_FFFF_FFFF_FFFF}}, 8'h00, 1'b0, 1'b0, 1'b0, 2'd2, "R3");
        for (int k = 0; k < NL; k++) rb[k*64 +: 64] = 64'(k + 1) << 40;
        issue({NL{64'hFFFF_FFFF_FFFF_FFFF}}, rb, '0, 8'h00, 1'b0, 1'b0, 1'b1, 2'd2, "R7");
        idle(5);

        // Reset with two operations in flight: both are discarded (R8).
        issue({NL{64'h1}}, {NL{64'h1}}, '0, 8'h00, 1'b0, 1'b0, 1'b0, 2'd2, "R8");
        issue({NL{64'h2}}, {NL{64'h2}}, '0, 8'h00, 1'b0, 1'b0, 1'b0, 2'd2, "R8");
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b1;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check_quiet("R8");
        end
        rd_ptr = wr_ptr;
        rst = 1'b0;
        issue({NL{64'h000F_FFFF_FFFF_FFFF}}, {NL{64'h0010_0000_0000_0001}},
              {NL{64'h5}}, 8'h00, 1'b0, 1'b0, 1'b0, 2'd2, "R2");
        idle(6);

        checks++;
        if (rd_ptr != wr_ptr) begin
            fails++;
            $display("FAIL R8: results received actual %0d expected %0d", rd_ptr, wr_ptr);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule